// File: doc/BRIEF.md
# Double-Buffered Crosspoint Switch Core

This block is a non-blocking crosspoint. It has 64 single-bit data lanes in and 64 lanes out. Each output lane has its own selector. The selector picks any one input lane, using a 7-bit control word that belongs to that output. Any number of outputs may listen to the same input.

Reconfiguration takes two stages. An addressed write places a new control word into the staging register of one output, and the live routing does not change. A separate commit pulse copies every staging register into the active control registers on one clock edge, so the whole switch changes routing at once.

A mode input chooses how data travels. In registered mode the data is captured on the clock at the input and again at the output. In flow-through mode the data reaches the outputs combinationally. An output whose control word has its disable bit set drives 0 and lowers its enable flag. The enable flag stands in for a high-impedance driver.

Top module: `xbar_switch`

## Requirements
- R1: Each output lane n shows the input lane whose binary number is held in bits [5:0] of its active control word. Every input index from 0 to 63 can be selected by every output.
- R2: A write updates only the staging register of the output whose binary number is on `wrAddr`. Addresses 0 and 63 are included.
- R3: Staged writes have no effect on `dataOut` or `outEn` until a commit.
- R4: A commit pulse copies all 64 staging registers into the active registers on the same clock edge. The new routing applies from that edge on.
- R5: Any number of writes may precede one commit. An output that was not rewritten keeps whatever its staging register already held.
- R6: When the write and commit strobes are high in the same cycle, the commit takes the staging contents from before that cycle's write. The written word goes live at the next commit.
- R7: An output whose active disable bit (bit 6 of the control word) is 1 drives `dataOut` low and drives `outEn` low. An enabled output drives `outEn` high.
- R8: With `clockedMode` = 1, the input and output are both registered. A change on `dataIn` appears on `dataOut` after the second rising clock edge, and not after the first.
- R9: With `clockedMode` = 0, `dataOut` follows `dataIn` combinationally, with no clock edge needed.
- R10: After reset, every staging and active control word is zero. Every output selects input 0 and is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the strobes, the control registers and the registered data path |
| rstN | input | 1 | Asynchronous reset, active low |
| clockedMode | input | 1 | 1 selects the registered data path, 0 selects flow-through |
| dataIn | input | 64 | Input data lanes |
| localStb | input | 1 | Single-cycle write strobe for one staging register |
| globalStb | input | 1 | Single-cycle commit strobe for all outputs |
| wrAddr | input | 6 | Binary number of the output whose staging register is written |
| wrSel | input | 6 | Input index to stage for that output |
| wrOff | input | 1 | Disable bit to stage for that output |
| dataOut | output | 64 | Output data lanes |
| outEn | output | 64 | Per-output enable flag, low when the output is disabled |

## Verification
A wrong staging word stays invisible until the next commit. It then shows as wrong routing on that one output in the cycle after the commit, or two cycles later in registered mode. A wrong active word, or a leak from staging into the live path, shows at once. It appears either as an output that changes before any commit, or as a wrong `outEn` bit. Walking a single 1 across all 64 inputs under each mapping exposes a selector that picks a neighbouring lane. Using both modes exposes a path that is missing a register or has one too many.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  // Strobes from the control decode to the configuration bank
  typedef struct packed {
    logic load;    // write one staging row this cycle
    logic commit;  // copy every staging row to active this cycle
  } xbarStb_t;

  function automatic int ctrlWidth(input int selBits);
    return selBits + 1;
  endfunction

endpackage

// File: rtl/xbar_ctrl.sv
module xbar_ctrl #(
  parameter int NUM_OUT = 64,
  parameter int ADDR_W  = $clog2(NUM_OUT)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     localStb,
  input  logic                     globalStb,
  input  logic [ADDR_W-1:0]        wrAddr,
  output xbar_pkg::xbarStb_t       stb,
  output logic [NUM_OUT-1:0]       rowWe
);

  always_comb begin
    stb.load   = localStb;
    stb.commit = globalStb;
  end

  // Binary-to-one-hot decode of the write address
  for (genvar g = 0; g < NUM_OUT; g++) begin : gDec
    assign rowWe[g] = localStb && (wrAddr == ADDR_W'(g));
  end

  // R2: a write strobe enables exactly one row, none otherwise
  a_r2_one_row: assert property (@(posedge clk) disable iff (!rstN)
    localStb |-> ($countones(rowWe) == 1));
  a_r2_no_row: assert property (@(posedge clk) disable iff (!rstN)
    !localStb |-> (rowWe == '0));

endmodule

// File: rtl/xbar_cfg.sv
module xbar_cfg #(
  parameter int NUM_OUT = 64,
  parameter int SEL_W   = 6,
  localparam int CW     = xbar_pkg::ctrlWidth(SEL_W)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  xbar_pkg::xbarStb_t        stb,
  input  logic [NUM_OUT-1:0]        rowWe,
  input  logic [CW-1:0]             wrWord,
  output logic [NUM_OUT*CW-1:0]     activeFlat
);

  logic [NUM_OUT*CW-1:0] stageFlat;

  for (genvar g = 0; g < NUM_OUT; g++) begin : gRow
    logic [CW-1:0] stageRow;
    logic [CW-1:0] activeRow;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageRow <= '0;
      end else if (stb.load && rowWe[g]) begin
        stageRow <= wrWord;
      end
    end

    // Commit reads stageRow before this edge's write (R6)
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        activeRow <= '0;
      end else if (stb.commit) begin
        activeRow <= stageRow;
      end
    end

    assign stageFlat[g*CW +: CW]  = stageRow;
    assign activeFlat[g*CW +: CW] = activeRow;
  end

  // R4 / R6: after a commit, active equals staging as it stood before the edge
  a_r4_commit_copy: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit |=> (activeFlat == $past(stageFlat)));
  // R3: without a commit the active bank is frozen
  a_r3_active_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.commit |=> $stable(activeFlat));
  // R2: without a write the staging bank is frozen
  a_r2_stage_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(stageFlat));

endmodule

// File: rtl/xbar_data.sv
module xbar_data #(
  parameter int NUM_IN  = 64,
  parameter int NUM_OUT = 64,
  parameter int SEL_W   = 6,
  localparam int CW     = SEL_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clockedMode,
  input  logic [NUM_IN-1:0]       dataIn,
  input  logic [NUM_OUT*CW-1:0]   activeFlat,
  output logic [NUM_OUT-1:0]      dataOut,
  output logic [NUM_OUT-1:0]      outEn
);

  logic [NUM_IN-1:0]  inReg;
  logic [NUM_IN-1:0]  srcVec;
  logic [NUM_OUT-1:0] pick;
  logic [NUM_OUT-1:0] pickEn;
  logic [NUM_OUT-1:0] outReg;
  logic [NUM_OUT-1:0] enReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inReg <= '0;
    else       inReg <= dataIn;
  end

  // Mode bypass at the input side
  assign srcVec = clockedMode ? inReg : dataIn;

  for (genvar g = 0; g < NUM_OUT; g++) begin : gSel
    logic [SEL_W-1:0] selIdx;
    logic             offBit;
    assign selIdx    = activeFlat[g*CW +: SEL_W];
    assign offBit    = activeFlat[g*CW + SEL_W];
    assign pick[g]   = offBit ? 1'b0 : srcVec[selIdx];
    assign pickEn[g] = !offBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg <= '0;
      enReg  <= '1;
    end else begin
      outReg <= pick;
      enReg  <= pickEn;
    end
  end

  // Mode bypass at the output side
  assign dataOut = clockedMode ? outReg : pick;
  assign outEn   = clockedMode ? enReg  : pickEn;

  // R7: a disabled lane never drives a 1
  a_r7_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
    ((dataOut & ~outEn) == '0));
  // R8: in registered mode the output lags the selector by one edge
  a_r8_reg_lag: assert property (@(posedge clk) disable iff (!rstN)
    (clockedMode && $past(clockedMode)) |-> (dataOut == $past(pick)));

endmodule

// File: rtl/xbar_switch.sv
module xbar_switch #(
  parameter int NUM_IN   = 64,
  parameter int NUM_OUT  = 64,
  localparam int SEL_W   = $clog2(NUM_IN),
  localparam int ADDR_W  = $clog2(NUM_OUT),
  localparam int CW      = SEL_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clockedMode,
  input  logic [NUM_IN-1:0]    dataIn,
  input  logic                 localStb,
  input  logic                 globalStb,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [SEL_W-1:0]     wrSel,
  input  logic                 wrOff,
  output logic [NUM_OUT-1:0]   dataOut,
  output logic [NUM_OUT-1:0]   outEn
);

  xbar_pkg::xbarStb_t        stb;
  logic [NUM_OUT-1:0]        rowWe;
  logic [NUM_OUT*CW-1:0]     activeFlat;

  xbar_ctrl #(.NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .localStb(localStb), .globalStb(globalStb),
    .wrAddr(wrAddr), .stb(stb), .rowWe(rowWe)
  );

  xbar_cfg #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) uCfg (
    .clk(clk), .rstN(rstN), .stb(stb), .rowWe(rowWe),
    .wrWord({wrOff, wrSel}), .activeFlat(activeFlat)
  );

  xbar_data #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .SEL_W(SEL_W)) uData (
    .clk(clk), .rstN(rstN), .clockedMode(clockedMode), .dataIn(dataIn),
    .activeFlat(activeFlat), .dataOut(dataOut), .outEn(outEn)
  );

endmodule

// File: tb/test_xbar_switch.sv
module test_xbar_switch;
  localparam int N = 64;
  localparam int W = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, clockedMode, localStb, globalStb, wrOff;
  logic [N-1:0] dataIn, dataOut, outEn;
  logic [W-1:0] wrAddr, wrSel;

  xbar_switch i_xbar_switch (
    .clk(clk), .rstN(rstN), .clockedMode(clockedMode), .dataIn(dataIn),
    .localStb(localStb), .globalStb(globalStb), .wrAddr(wrAddr),
    .wrSel(wrSel), .wrOff(wrOff), .dataOut(dataOut), .outEn(outEn)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [W-1:0] stSel [N];
  logic [W-1:0] acSel [N];
  logic         stOff [N];
  logic         acOff [N];

  function automatic logic [N-1:0] expOut(input logic [N-1:0] d);
    logic [N-1:0] r;
    for (int n = 0; n < N; n++) r[n] = acOff[n] ? 1'b0 : d[acSel[n]];
    return r;
  endfunction

  function automatic logic [N-1:0] expEn();
    logic [N-1:0] r;
    for (int n = 0; n < N; n++) r[n] = !acOff[n];
    return r;
  endfunction

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    if (clockedMode) begin
      repeat (2) @(posedge clk);
      @(negedge clk);
    end else begin
      #2;
    end
  endtask

  task automatic applyCheck(input string req, input logic [N-1:0] d);
    dataIn = d;
    settle();
    check(req, dataOut, expOut(d));
    check(req, outEn, expEn());
  endtask

  task automatic stage(input int a, input int s, input logic o);
    @(negedge clk);
    wrAddr = W'(a); wrSel = W'(s); wrOff = o; localStb = 1'b1;
    @(negedge clk);
    localStb = 1'b0;
    stSel[a] = W'(s); stOff[a] = o;
  endtask

  task automatic commit();
    @(negedge clk);
    globalStb = 1'b1;
    @(negedge clk);
    globalStb = 1'b0;
    for (int n = 0; n < N; n++) begin acSel[n] = stSel[n]; acOff[n] = stOff[n]; end
  endtask

  task automatic stageAndCommit(input int a, input int s, input logic o);
    @(negedge clk);
    wrAddr = W'(a); wrSel = W'(s); wrOff = o; localStb = 1'b1; globalStb = 1'b1;
    @(negedge clk);
    localStb = 1'b0; globalStb = 1'b0;
    for (int n = 0; n < N; n++) begin acSel[n] = stSel[n]; acOff[n] = stOff[n]; end
    stSel[a] = W'(s); stOff[a] = o;
  endtask

  function automatic logic [N-1:0] rnd();
    return {$urandom(), $urandom()};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] oldD, newD;
    rstN = 1'b0; clockedMode = 1'b0; localStb = 1'b0; globalStb = 1'b0;
    wrOff = 1'b0; wrAddr = '0; wrSel = '0; dataIn = '0;
    for (int n = 0; n < N; n++) begin stSel[n] = '0; acSel[n] = '0; stOff[n] = 0; acOff[n] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10: reset routes every output to input 0, all enabled
    dataIn = 64'h1;
    #2;
    check("R10", dataOut, '1);
    check("R10", outEn, '1);
    applyCheck("R10", 64'hFFFF_FFFF_FFFF_FFFE);

    for (int m = 0; m < 2; m++) begin
      clockedMode = m[0];
      oldD = rnd();
      applyCheck("R1", oldD);
      // Stage a full new mapping with some outputs disabled
      for (int n = 0; n < N; n++)
        stage(n, (n * (5 + 2 * m) + 3 + m) % N, ((n + m) % 5) == 2);
      // R3: nothing changes before commit
      settle();
      check("R3", dataOut, expOut(oldD));
      check("R3", outEn, expEn());
      applyCheck("R3", rnd());
      commit();
      // R4 / R1: full mapping after commit, walking one over every input
      for (int i = 0; i < N; i++) applyCheck("R1", 64'h1 << i);
      applyCheck("R4", rnd());
      applyCheck("R4", 64'hAAAA_AAAA_AAAA_AAAA);
      // R7: disabled lanes low even with all-ones input
      applyCheck("R7", '1);
      // R2 / R5: address boundaries and a partial update
      stage(0, 63, 1'b0);
      stage(63, 0, 1'b0);
      stage(17, 17, 1'b1);
      applyCheck("R3", '1);
      commit();
      applyCheck("R2", 64'h8000_0000_0000_0001);
      applyCheck("R5", rnd());
      applyCheck("R7", '1);
      // R6: write and commit in the same cycle
      stage(5, 40, 1'b0);
      stageAndCommit(5, 9, 1'b0);
      applyCheck("R6", 64'h1 << 40);
      applyCheck("R6", 64'h1 << 9);
      commit();
      applyCheck("R6", 64'h1 << 9);
      applyCheck("R6", rnd());
    end

    // R8: registered latency of two edges
    clockedMode = 1'b1;
    oldD = rnd();
    applyCheck("R8", oldD);
    newD = ~oldD;
    dataIn = newD;
    @(posedge clk); @(negedge clk);
    check("R8", dataOut, expOut(oldD));
    @(posedge clk); @(negedge clk);
    check("R8", dataOut, expOut(newD));

    // R9: flow-through updates with no clock edge
    clockedMode = 1'b0;
    @(negedge clk);
    dataIn = oldD;
    #1;
    check("R9", dataOut, expOut(oldD));
    dataIn = newD;
    #1;
    check("R9", dataOut, expOut(newD));

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule